// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

The block collects up to 32 interrupt lines and turns them into two request outputs: a normal request and a fast request. Each input line first goes through a shared conditioning stage. This stage can invert the line, and it can either pass the level straight through or hold a rising condition in a latch until software acknowledges it. Each source also carries a 4-bit priority, where a smaller value is more urgent.

Each of the two banks keeps its own enable mask and its own priority ceiling. It combines these with the conditioned lines to form a status vector. From that vector it picks one winning source by priority, and on a tie the lowest source number wins. Software reaches everything through a simple 32-bit register bus. The normal bank occupies byte offsets 0x000 to 0x02C and the fast bank the same offsets plus 0x100. Software services a bank by reading its winner, and it clears a held event by reading the bank's acknowledge register.

Read data is registered. It appears after the clock edge that accepts the read and stays on the bus until the next read.

Top module: `dual_bank_intc`

## Requirements
- R1: A source is passed through unchanged when its bit in the inversion word (0x200) is 1 and is inverted when the bit is 0. The inversion word resets to all ones and reads back as written.
- R2: A source whose bit in the hold-select word (0x204, reset 0) is 0 appears in raw status (bank +0x04) in the same cycle as its conditioned level. When the bit is 1, the conditioned level sets a latch at the clock edge, and raw status shows that latch until it is acknowledged.
- R3: Writing ones to bank +0x08 sets the matching enable bits, and writing ones to bank +0x0C clears them. Both offsets read back the enable mask, which resets to 0. Writing all ones to +0x0C clears every enable bit.
- R4: Bank status (+0x00) is raw status AND the bank's enable mask, limited to sources whose priority value is less than or equal to the bank ceiling.
- R5: Among the status bits, the source with the smallest priority value wins, and ties go to the lowest source number. Bank +0x20 reads the winner's number, which is also driven on that bank's id output.
- R6: A bank's request output is 1 exactly when its status is nonzero. Its id output is 0 when the request is low.
- R7: The bank ceiling (+0x2C) keeps the low 4 bits of a write and resets to 0xF. A source whose priority value exceeds the ceiling is left out of status.
- R8: Reading bank +0x28 returns the winner's number and clears that source's held latch. If the conditioned level is still 1 at that edge, the latch sets again. Level-mode sources and the other bank's winners are unaffected.
- R9: The fast bank at 0x100 uses the same layout with its own enable mask and ceiling. It shares raw status with the normal bank, and writes to one bank do not change the other.
- R10: The priority of source n sits at 0x300 + 4*n. It keeps the low 4 bits of a write, reads back zero-extended, and resets to 0.
- R11: Reads of unmapped or unaligned addresses return 0. Writes to read-only offsets change no state.
- R12: Read data updates only on the clock edge that accepts a read and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt lines |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal bank request |
| fiq_o | output | 1 | Fast bank request |
| irq_id_o | output | 5 | Normal bank winning source |
| fiq_id_o | output | 5 | Fast bank winning source |

## Verification
The arbiter is tried with several input patterns:
- Two enabled sources of equal priority check the tie-break on source number.
- Giving one source a less urgent value then checks that priority value ranks ahead of index.
- Lowering the ceiling step by step separates filtering from ranking.

Inverting a low line shows that inversion happens before arbitration. A single-cycle pulse on a held source, a held source that is still high when acknowledged, and a level source that is acknowledged together separate latch capture, re-arming and the level path. Setting enables and ceilings in one bank while the other is watched shows that the banks are isolated.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int NUM_BANKS = 2;

  // address regions, bits [11:8]
  localparam logic [3:0] RGN_CFG  = 4'h2;
  localparam logic [3:0] RGN_PRIO = 4'h3;

  // per-bank word offsets, bits [7:0]
  localparam logic [7:0] BK_STATUS = 8'h00;
  localparam logic [7:0] BK_RAW    = 8'h04;
  localparam logic [7:0] BK_EN_SET = 8'h08;
  localparam logic [7:0] BK_EN_CLR = 8'h0C;
  localparam logic [7:0] BK_WINNER = 8'h20;
  localparam logic [7:0] BK_ACK    = 8'h28;
  localparam logic [7:0] BK_CEIL   = 8'h2C;

  localparam logic [7:0] CFG_INV  = 8'h00;
  localparam logic [7:0] CFG_HOLD = 8'h04;

  typedef enum logic [0:0] {
    BANK_NORM = 1'b0,
    BANK_FAST = 1'b1
  } bank_e;
endpackage

// File: rtl/intc_cond.sv
module intc_cond #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] pass_sel_i,
  input  logic [N_SRC-1:0] hold_sel_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] raw_o
);
  logic [N_SRC-1:0] cond;
  logic [N_SRC-1:0] held_q, held_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    // pass bit 1 keeps polarity
    assign cond[i]   = pass_sel_i[i] ? src_i[i] : ~src_i[i];
    // clear then re-capture: a still-active line re-arms in the same edge
    assign held_d[i] = hold_sel_i[i] & ((held_q[i] & ~ack_clr_i[i]) | cond[i]);
    assign raw_o[i]  = hold_sel_i[i] ? held_q[i] : cond[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= held_d;
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             status_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         valid_o,
  output logic [SRC_W-1:0]             id_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest index on equal priority
  always_comb begin
    valid_o = 1'b0;
    best    = '1;
    id_o    = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (status_i[i] && (!valid_o || prio_i[i] < best)) begin
        valid_o = 1'b1;
        best    = prio_i[i];
        id_o    = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SRC-1:0]             raw_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [N_SRC-1:0]             en_set_i,
  input  logic [N_SRC-1:0]             en_clr_i,
  input  logic                         ceil_we_i,
  input  logic [PRIO_W-1:0]            ceil_wdata_i,
  output logic [N_SRC-1:0]             en_o,
  output logic [PRIO_W-1:0]            ceil_o,
  output logic [N_SRC-1:0]             status_o,
  output logic                         req_o,
  output logic [SRC_W-1:0]             id_o
);
  logic [N_SRC-1:0]  en_q;
  logic [PRIO_W-1:0] ceil_q;
  logic [N_SRC-1:0]  in_range;
  logic              arb_valid;
  logic [SRC_W-1:0]  arb_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      ceil_q <= '1;
    end else begin
      en_q <= (en_q | en_set_i) & ~en_clr_i;
      if (ceil_we_i) ceil_q <= ceil_wdata_i;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_ceil
    assign in_range[i] = (prio_i[i] <= ceil_q);
  end

  assign status_o = raw_i & en_q & in_range;

  intc_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .status_i (status_o),
    .prio_i   (prio_i),
    .valid_o  (arb_valid),
    .id_o     (arb_id)
  );

  assign req_o  = |status_o;
  assign id_o   = arb_valid ? arb_id : '0;
  assign en_o   = en_q;
  assign ceil_o = ceil_q;
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [SRC_W-1:0]  irq_id_o,
  output logic [SRC_W-1:0]  fiq_id_o
);
  logic [3:0] region;
  logic [7:0] offset;
  logic [5:0] pidx;
  logic       aligned, wr_stb, rd_stb;

  assign region  = bus_addr_i[11:8];
  assign offset  = bus_addr_i[7:0];
  assign pidx    = bus_addr_i[7:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign wr_stb  = bus_req_i & bus_we_i & aligned;
  assign rd_stb  = bus_req_i & ~bus_we_i & aligned;

  // shared configuration
  logic [N_SRC-1:0]             pass_q, hold_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_SRC-1:0]             raw_w, ack_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= '1;
      hold_q <= '0;
    end else if (wr_stb && region == RGN_CFG) begin
      if (offset == CFG_INV)  pass_q <= bus_wdata_i[N_SRC-1:0];
      if (offset == CFG_HOLD) hold_q <= bus_wdata_i[N_SRC-1:0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    logic hit;
    assign hit = wr_stb && region == RGN_PRIO && pidx == 6'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  prio_q[i] <= '0;
      else if (hit) prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  intc_cond #(.N_SRC(N_SRC)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .pass_sel_i (pass_q),
    .hold_sel_i (hold_q),
    .ack_clr_i  (ack_clr),
    .raw_o      (raw_w)
  );

  // banks
  logic [N_SRC-1:0]  en_w     [NUM_BANKS];
  logic [N_SRC-1:0]  status_w [NUM_BANKS];
  logic [PRIO_W-1:0] ceil_w   [NUM_BANKS];
  logic              req_w    [NUM_BANKS];
  logic [SRC_W-1:0]  id_w     [NUM_BANKS];
  logic [N_SRC-1:0]  bank_ack [NUM_BANKS];
  logic [DATA_W-1:0] bank_rd  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [3:0] RGN = 4'(b);
    logic             hit;
    logic [N_SRC-1:0] set_m, clr_m;
    logic             ceil_we;

    assign hit     = (region == RGN);
    assign set_m   = (wr_stb && hit && offset == BK_EN_SET) ? bus_wdata_i[N_SRC-1:0] : '0;
    assign clr_m   = (wr_stb && hit && offset == BK_EN_CLR) ? bus_wdata_i[N_SRC-1:0] : '0;
    assign ceil_we = wr_stb && hit && offset == BK_CEIL;

    intc_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .raw_i        (raw_w),
      .prio_i       (prio_q),
      .en_set_i     (set_m),
      .en_clr_i     (clr_m),
      .ceil_we_i    (ceil_we),
      .ceil_wdata_i (bus_wdata_i[PRIO_W-1:0]),
      .en_o         (en_w[b]),
      .ceil_o       (ceil_w[b]),
      .status_o     (status_w[b]),
      .req_o        (req_w[b]),
      .id_o         (id_w[b])
    );

    always_comb begin
      bank_ack[b] = '0;
      if (rd_stb && hit && offset == BK_ACK && req_w[b]) bank_ack[b][id_w[b]] = 1'b1;
    end

    always_comb begin
      unique case (offset)
        BK_STATUS:            bank_rd[b] = DATA_W'(status_w[b]);
        BK_RAW:               bank_rd[b] = DATA_W'(raw_w);
        BK_EN_SET, BK_EN_CLR: bank_rd[b] = DATA_W'(en_w[b]);
        BK_WINNER, BK_ACK:    bank_rd[b] = DATA_W'(id_w[b]);
        BK_CEIL:              bank_rd[b] = DATA_W'(ceil_w[b]);
        default:              bank_rd[b] = '0;
      endcase
    end
  end

  always_comb begin
    ack_clr = '0;
    for (int b = 0; b < NUM_BANKS; b++) ack_clr = ack_clr | bank_ack[b];
  end

  // read path
  logic [DATA_W-1:0] cfg_rd, prio_rd, rd_mux, rdata_q;

  always_comb begin
    unique case (offset)
      CFG_INV:  cfg_rd = DATA_W'(pass_q);
      CFG_HOLD: cfg_rd = DATA_W'(hold_q);
      default:  cfg_rd = '0;
    endcase
  end

  always_comb begin
    prio_rd = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pidx == 6'(i)) prio_rd = DATA_W'(prio_q[i]);
    end
  end

  always_comb begin
    unique case (region)
      4'h0:     rd_mux = bank_rd[BANK_NORM];
      4'h1:     rd_mux = bank_rd[BANK_FAST];
      RGN_CFG:  rd_mux = cfg_rd;
      RGN_PRIO: rd_mux = prio_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rdata_q <= '0;
    else if (bus_req_i && !bus_we_i)    rdata_q <= aligned ? rd_mux : '0;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = req_w[BANK_NORM];
  assign fiq_o       = req_w[BANK_FAST];
  assign irq_id_o    = id_w[BANK_NORM];
  assign fiq_id_o    = id_w[BANK_FAST];
endmodule

module dual_bank_intc_chk #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [N_SRC-1:0]             src_i,
  input logic                         bus_req_i,
  input logic                         bus_we_i,
  input logic [11:0]                  bus_addr_i,
  input logic [31:0]                  bus_wdata_i,
  input logic [31:0]                  bus_rdata_o,
  input logic                         irq_o,
  input logic                         fiq_o,
  input logic [SRC_W-1:0]             irq_id_o,
  input logic [SRC_W-1:0]             fiq_id_o,
  input logic [N_SRC-1:0]             raw_i,
  input logic [N_SRC-1:0]             pass_i,
  input logic [N_SRC-1:0]             hold_i,
  input logic [N_SRC-1:0]             en_norm_i,
  input logic [N_SRC-1:0]             en_fast_i,
  input logic [PRIO_W-1:0]            ceil_norm_i,
  input logic [PRIO_W-1:0]            ceil_fast_i,
  input logic [N_SRC-1:0][PRIO_W-1:0] prio_i
);
  assert_norm_winner_eligible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_norm_i[irq_id_o] && raw_i[irq_id_o] && prio_i[irq_id_o] <= ceil_norm_i));

  assert_fast_winner_eligible_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (en_fast_i[fiq_id_o] && raw_i[fiq_id_o] && prio_i[fiq_id_o] <= ceil_fast_i));

  assert_idle_id_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o |-> irq_id_o == '0) and (!fiq_o |-> fiq_id_o == '0));

  assert_enable_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == 12'h008)
      |=> en_norm_i == ($past(en_norm_i) | $past(bus_wdata_i[N_SRC-1:0])));

  assert_disable_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == 12'h00C && bus_wdata_i == '1) |=> en_norm_i == '0);

  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i[11:10] != 2'b00) |=> bus_rdata_o == '0);

  assert_ack_clears_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == 12'h028 && irq_o && hold_i[irq_id_o]
     && !(src_i[irq_id_o] ~^ pass_i[irq_id_o]))
      |=> !raw_i[$past(irq_id_o)]);

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o));
endmodule

bind dual_bank_intc dual_bank_intc_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .irq_id_o    (irq_id_o),
  .fiq_id_o    (fiq_id_o),
  .raw_i       (raw_w),
  .pass_i      (pass_q),
  .hold_i      (hold_q),
  .en_norm_i   (en_w[0]),
  .en_fast_i   (en_w[1]),
  .ceil_norm_i (ceil_w[0]),
  .ceil_fast_i (ceil_w[1]),
  .prio_i      (prio_q)
);

// File: tb/dual_bank_intc_tb.sv
module dual_bank_intc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  logic [4:0]  irq_id, fiq_id;

  int checks = 0;
  int failures = 0;
  logic        rd_fire = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_intc dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_i       (src),
    .bus_req_i   (bus_req),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .fiq_o       (fiq),
    .irq_id_o    (irq_id),
    .fiq_id_o    (fiq_id)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // driver: issue read and queue the expected word
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  always @(posedge clk) rd_fire <= rst_n && bus_req && !bus_we;

  // monitor: compare each returned word against the queue head
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(12'h200, 32'hFFFF_FFFF, "R1 inversion reset");
    wr(12'h204, 32'h0);
    check("R12 rdata held across write", rdata, 32'hFFFF_FFFF);
    rd(12'h204, 32'h0, "R2 hold reset");
    rd(12'h008, 32'h0, "R3 enable reset");
    rd(12'h02C, 32'hF, "R7 ceiling reset");
    rd(12'h12C, 32'hF, "R9 fast ceiling reset");
    rd(12'h37C, 32'h0, "R10 prio31 reset");
    check("R6 irq idle", {31'b0, irq}, 32'h0);
    check("R6 fiq idle", {31'b0, fiq}, 32'h0);

    // level sources, tie-break
    src = 32'h30; #1;
    rd(12'h004, 32'h30, "R2 raw level");
    rd(12'h000, 32'h0, "R4 status masked");
    wr(12'h008, 32'hF0);
    rd(12'h008, 32'hF0, "R3 enable set");
    rd(12'h00C, 32'hF0, "R3 disable reads mask");
    rd(12'h000, 32'h30, "R4 status");
    rd(12'h020, 32'h4, "R5 tie lowest index");
    check("R6 irq high", {31'b0, irq}, 32'h1);
    check("R5 irq id", {27'b0, irq_id}, 32'h4);
    check("R9 fiq off", {31'b0, fiq}, 32'h0);
    rd(12'h104, 32'h30, "R9 shared raw");
    rd(12'h100, 32'h0, "R9 fast status");

    // priority ranking and ceiling
    wr(12'h310, 32'h5);
    wr(12'h314, 32'hFFFF_FFF3);
    rd(12'h314, 32'h3, "R10 prio low bits");
    rd(12'h020, 32'h5, "R5 lowest prio wins");
    check("R5 irq id prio", {27'b0, irq_id}, 32'h5);
    wr(12'h02C, 32'h4);
    rd(12'h000, 32'h20, "R7 ceiling filters");
    wr(12'h02C, 32'h2);
    check("R7 irq dropped", {31'b0, irq}, 32'h0);
    check("R6 id zero idle", {27'b0, irq_id}, 32'h0);
    rd(12'h000, 32'h0, "R7 status empty");
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h02C, 32'hF, "R7 ceiling width");

    wr(12'h00C, 32'h20);
    rd(12'h008, 32'hD0, "R3 disable clears");
    rd(12'h020, 32'h4, "R3 winner after disable");

    // inversion
    wr(12'h200, 32'hFFFF_FF7F);
    rd(12'h004, 32'hB0, "R1 inverted line");
    rd(12'h020, 32'h7, "R1 inverted source wins");
    wr(12'h200, 32'hFFFF_FFFF);

    // fast bank
    wr(12'h108, 32'h1);
    src = 32'h31; #1;
    check("R9 fiq high", {31'b0, fiq}, 32'h1);
    check("R9 fiq id", {27'b0, fiq_id}, 32'h0);
    rd(12'h120, 32'h0, "R9 fast winner");
    rd(12'h000, 32'h10, "R9 normal unaffected");
    rd(12'h108, 32'h1, "R9 fast enable");
    wr(12'h300, 32'h1);
    wr(12'h12C, 32'h0);
    check("R7 fast ceiling drops", {31'b0, fiq}, 32'h0);
    check("R9 normal keeps req", {31'b0, irq}, 32'h1);
    check("R9 normal id", {27'b0, irq_id}, 32'h4);
    wr(12'h12C, 32'hF);
    check("R9 fiq restored", {31'b0, fiq}, 32'h1);
    wr(12'h300, 32'h0);

    // held capture and acknowledge
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h008, 32'h0, "R3 disable all");
    wr(12'h10C, 32'hFFFF_FFFF);
    src = 32'h0;
    wr(12'h204, 32'h100);
    wr(12'h008, 32'h110);
    @(negedge clk); src = 32'h100;
    @(negedge clk); src = 32'h0; #1;
    check("R2 held pulse req", {31'b0, irq}, 32'h1);
    check("R2 held pulse id", {27'b0, irq_id}, 32'h8);
    rd(12'h004, 32'h100, "R2 latch holds");
    rd(12'h028, 32'h8, "R8 ack returns winner");
    rd(12'h004, 32'h0, "R8 latch cleared");
    check("R8 req dropped", {31'b0, irq}, 32'h0);

    src = 32'h100;
    @(negedge clk);
    rd(12'h028, 32'h8, "R8 ack while active");
    rd(12'h004, 32'h100, "R8 re-arm");
    src = 32'h0;
    rd(12'h004, 32'h100, "R8 still latched");
    rd(12'h028, 32'h8, "R8 second ack");
    rd(12'h004, 32'h0, "R8 cleared after release");

    src = 32'h10;
    rd(12'h028, 32'h4, "R8 level ack id");
    rd(12'h004, 32'h10, "R8 level unaffected");
    @(negedge clk); src = 32'h110;
    @(negedge clk); src = 32'h10;
    rd(12'h128, 32'h0, "R9 fast ack idle");
    rd(12'h004, 32'h110, "R8 fast ack leaves latch");

    // unmapped and read-only
    rd(12'h400, 32'h0, "R11 unmapped high");
    rd(12'h030, 32'h0, "R11 unmapped bank offset");
    rd(12'h208, 32'h0, "R11 unmapped cfg");
    rd(12'h009, 32'h0, "R11 unaligned");
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h008, 32'h110, "R11 read-only write ignored");
    rd(12'h02C, 32'hF, "R11 ceiling untouched");
    repeat (4) @(negedge clk);
    check("R12 rdata holds", rdata, 32'hF);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R12 missing read data actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule